// File: doc/BRIEF.md
# Two-Deep Writeback Operand Forwarding Unit

This unit supplies source operands to the instruction in the operand stage of a short in-order pipeline. The register file is synchronous on-chip memory. A value committed in the last few cycles may therefore not be readable from it yet. The unit remembers the two most recent register writes as index/value records. For each read port it chooses the newest copy of the requested register from four places, newest first:

- the write being committed this cycle by the execute stage;
- the newer saved record;
- the older saved record;
- the register-file read data.

The older record exists for one case. A load must commit at the edge that ends its execute cycle, even while the pipeline is stalled, because its memory data is valid only until that edge. That commit pushes the previous write out of the newer record. A reader still held in the operand stage must then find the value it needs one record further back. Register 0 reads as zero and is never recorded. Both read ports apply the same choice independently of each other.

Top module: `wbfwd_top`

## Requirements
- R1: When the commit-valid input is high with a nonzero commit index equal to a port's read index, that port outputs the commit data, whatever the saved records hold.
- R2: When R1 does not apply and the newer record is valid with an index equal to the read index, the port outputs the newer record's value.
- R3: When neither R1 nor R2 applies and the older record is valid with a matching index, the port outputs the older record's value.
- R4: When no source matches a nonzero read index, the port outputs its register-file data input unchanged.
- R5: A commit with a nonzero index is visible in the records from the following cycle. The newer record then holds that commit's index and data, and the older record holds what the newer record held before.
- R6: Read index 0 always yields zero, even while a commit to index 0 is presented. A commit to index 0 leaves both records unchanged.
- R7: Reset clears the valid bit of both records. A record that is not valid never matches, so after reset every nonzero read returns the register-file data until commits arrive.
- R8: Commits update the records whether or not the stall input is high. A reader held through a stall that sees one later commit finds its operand in the older record.
- R9: Each read port makes its choice from its own read index and register-file data only. Two ports reading different registers in the same cycle each get their own correct value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the surrounding logic |
| stall_i | input | 1 | Pipeline is holding the operand-stage instruction this cycle |
| commit_vld_i | input | 1 | Execute stage commits a register write this cycle |
| commit_idx_i | input | IDX_W (5) | Destination register of the commit |
| commit_data_i | input | DATA_W (32) | Value being committed |
| rd_idx_i | input | NUM_RD*IDX_W (10) | Read register index per port, port 0 in the low bits |
| rf_data_i | input | NUM_RD*DATA_W (64) | Register-file read data per port, port 0 in the low bits |
| opnd_o | output | NUM_RD*DATA_W (64) | Selected operand per port, port 0 in the low bits |

## Verification
The bench builds the unit with its defaults: 32-bit data, 5-bit register indices and two read ports. The small index space makes random index collisions common. Random stimulus therefore keeps producing back-to-back writes to one register, reads that hit both saved records at once, and writes to register 0. Two ports let one cycle check a stalled reader's older-record hit next to a newer-record or commit hit on the other port. A reference model of program order drives a register file that trails by two commits, and this model checks every cycle of the random run.

// File: rtl/wbfwd_pkg.sv
`timescale 1ns/1ps
package wbfwd_pkg;

  // Operand source chosen for one read port, in descending priority after zero.
  typedef enum logic [2:0] {
    SRC_ZERO = 3'd0,
    SRC_EXEC = 3'd1,
    SRC_NEW  = 3'd2,
    SRC_OLD  = 3'd3,
    SRC_RF   = 3'd4
  } opnd_src_e;

  // Number of saved write records kept by the history.
  localparam int unsigned HIST_DEPTH = 2;

endpackage

// File: rtl/wbfwd_history.sv
`timescale 1ns/1ps
module wbfwd_history #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic              new_vld_o,
  output logic [IDX_W-1:0]  new_idx_o,
  output logic [DATA_W-1:0] new_data_o,
  output logic              old_vld_o,
  output logic [IDX_W-1:0]  old_idx_o,
  output logic [DATA_W-1:0] old_data_o
);

  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic              new_vld_q, new_vld_d;
  logic [IDX_W-1:0]  new_idx_q, new_idx_d;
  logic [DATA_W-1:0] new_data_q, new_data_d;
  logic              old_vld_q, old_vld_d;
  logic [IDX_W-1:0]  old_idx_q, old_idx_d;
  logic [DATA_W-1:0] old_data_q, old_data_d;
  logic              shift_en;

  // Writes to register 0 are discarded; the stall has no say in recording.
  assign shift_en = wr_en_i && (wr_idx_i != ZERO_IDX);

  always_comb begin
    new_vld_d  = new_vld_q;
    new_idx_d  = new_idx_q;
    new_data_d = new_data_q;
    old_vld_d  = old_vld_q;
    old_idx_d  = old_idx_q;
    old_data_d = old_data_q;
    if (shift_en) begin
      new_vld_d  = 1'b1;
      new_idx_d  = wr_idx_i;
      new_data_d = wr_data_i;
      old_vld_d  = new_vld_q;
      old_idx_d  = new_idx_q;
      old_data_d = new_data_q;
    end
  end

  // Valid bits carry the reset; payload registers are enable-only.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      new_vld_q <= 1'b0;
      old_vld_q <= 1'b0;
    end else begin
      new_vld_q <= new_vld_d;
      old_vld_q <= old_vld_d;
    end
  end

  always_ff @(posedge clk) begin
    if (shift_en) begin
      new_idx_q  <= new_idx_d;
      new_data_q <= new_data_d;
      old_idx_q  <= old_idx_d;
      old_data_q <= old_data_d;
    end
  end

  assign new_vld_o  = new_vld_q;
  assign new_idx_o  = new_idx_q;
  assign new_data_o = new_data_q;
  assign old_vld_o  = old_vld_q;
  assign old_idx_o  = old_idx_q;
  assign old_data_o = old_data_q;

  // R5
  rec_new_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i != ZERO_IDX) |=>
      (new_vld_o && new_idx_o == $past(wr_idx_i) && new_data_o == $past(wr_data_i)));

  // R5
  rec_old_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && wr_idx_i != ZERO_IDX) |=>
      (old_vld_o == $past(new_vld_o) &&
       (!$past(new_vld_o) || (old_idx_o == $past(new_idx_o) && old_data_o == $past(new_data_o)))));

  // R6
  zero_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en_i || wr_idx_i == ZERO_IDX) |=>
      ($stable(new_vld_o) && $stable(old_vld_o) &&
       (!new_vld_o || ($stable(new_idx_o) && $stable(new_data_o)))));

  // R8
  stall_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall_i && wr_en_i && wr_idx_i != ZERO_IDX) |=> (new_idx_o == $past(wr_idx_i)));

  // R7
  rec_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    old_vld_o |-> new_vld_o);

endmodule

// File: rtl/wbfwd_prio.sv
`timescale 1ns/1ps
module wbfwd_prio
  import wbfwd_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic             ex_vld_i,
  input  logic [IDX_W-1:0] ex_idx_i,
  input  logic             new_vld_i,
  input  logic [IDX_W-1:0] new_idx_i,
  input  logic             old_vld_i,
  input  logic [IDX_W-1:0] old_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output opnd_src_e        src_o
);

  localparam logic [IDX_W-1:0] ZERO_IDX = '0;

  logic hit_ex, hit_new, hit_old, rd_zero;

  assign rd_zero = (rd_idx_i == ZERO_IDX);
  assign hit_ex  = ex_vld_i  && (ex_idx_i  == rd_idx_i);
  assign hit_new = new_vld_i && (new_idx_i == rd_idx_i);
  assign hit_old = old_vld_i && (old_idx_i == rd_idx_i);

  always_comb begin
    if (rd_zero)      src_o = SRC_ZERO;
    else if (hit_ex)  src_o = SRC_EXEC;
    else if (hit_new) src_o = SRC_NEW;
    else if (hit_old) src_o = SRC_OLD;
    else              src_o = SRC_RF;
  end

endmodule

// File: rtl/wbfwd_port.sv
`timescale 1ns/1ps
module wbfwd_port
  import wbfwd_pkg::*;
#(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ex_vld_i,
  input  logic [IDX_W-1:0]  ex_idx_i,
  input  logic [DATA_W-1:0] ex_data_i,
  input  logic              new_vld_i,
  input  logic [IDX_W-1:0]  new_idx_i,
  input  logic [DATA_W-1:0] new_data_i,
  input  logic              old_vld_i,
  input  logic [IDX_W-1:0]  old_idx_i,
  input  logic [DATA_W-1:0] old_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic [DATA_W-1:0] rf_data_i,
  output logic [DATA_W-1:0] opnd_o
);

  opnd_src_e src;

  wbfwd_prio #(.IDX_W(IDX_W)) u_prio (
    .ex_vld_i  (ex_vld_i),
    .ex_idx_i  (ex_idx_i),
    .new_vld_i (new_vld_i),
    .new_idx_i (new_idx_i),
    .old_vld_i (old_vld_i),
    .old_idx_i (old_idx_i),
    .rd_idx_i  (rd_idx_i),
    .src_o     (src)
  );

  always_comb begin
    unique case (src)
      SRC_ZERO: opnd_o = '0;
      SRC_EXEC: opnd_o = ex_data_i;
      SRC_NEW:  opnd_o = new_data_i;
      SRC_OLD:  opnd_o = old_data_i;
      default:  opnd_o = rf_data_i;
    endcase
  end

  // R6
  zero_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_i == '0) |-> (opnd_o == '0));

  // R1
  exec_win_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_vld_i && ex_idx_i == rd_idx_i && rd_idx_i != '0) |-> (opnd_o == ex_data_i));

  // R4
  rf_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx_i != '0 && !(ex_vld_i && ex_idx_i == rd_idx_i) &&
     !(new_vld_i && new_idx_i == rd_idx_i) && !(old_vld_i && old_idx_i == rd_idx_i))
      |-> (opnd_o == rf_data_i));

endmodule

// File: rtl/wbfwd_top.sv
`timescale 1ns/1ps
module wbfwd_top #(
  parameter int unsigned IDX_W  = 5,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned NUM_RD = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     stall_i,
  input  logic                     commit_vld_i,
  input  logic [IDX_W-1:0]         commit_idx_i,
  input  logic [DATA_W-1:0]        commit_data_i,
  input  logic [NUM_RD*IDX_W-1:0]  rd_idx_i,
  input  logic [NUM_RD*DATA_W-1:0] rf_data_i,
  output logic [NUM_RD*DATA_W-1:0] opnd_o
);

  logic              new_vld, old_vld;
  logic [IDX_W-1:0]  new_idx, old_idx;
  logic [DATA_W-1:0] new_data, old_data;

  wbfwd_history #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_hist (
    .clk        (clk),
    .rst_n      (rst_n),
    .stall_i    (stall_i),
    .wr_en_i    (commit_vld_i),
    .wr_idx_i   (commit_idx_i),
    .wr_data_i  (commit_data_i),
    .new_vld_o  (new_vld),
    .new_idx_o  (new_idx),
    .new_data_o (new_data),
    .old_vld_o  (old_vld),
    .old_idx_o  (old_idx),
    .old_data_o (old_data)
  );

  // R9: one independent selector per read port.
  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    wbfwd_port #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_port (
      .clk        (clk),
      .rst_n      (rst_n),
      .ex_vld_i   (commit_vld_i),
      .ex_idx_i   (commit_idx_i),
      .ex_data_i  (commit_data_i),
      .new_vld_i  (new_vld),
      .new_idx_i  (new_idx),
      .new_data_i (new_data),
      .old_vld_i  (old_vld),
      .old_idx_i  (old_idx),
      .old_data_i (old_data),
      .rd_idx_i   (rd_idx_i[p*IDX_W +: IDX_W]),
      .rf_data_i  (rf_data_i[p*DATA_W +: DATA_W]),
      .opnd_o     (opnd_o[p*DATA_W +: DATA_W])
    );
  end

endmodule

// File: tb/wbfwd_top_bench.sv
`timescale 1ns/1ps
module wbfwd_top_bench;

  localparam int IW = 5;
  localparam int DW = 32;
  localparam int NR = 2;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             stall_i;
  logic             commit_vld_i;
  logic [IW-1:0]    commit_idx_i;
  logic [DW-1:0]    commit_data_i;
  logic [NR*IW-1:0] rd_idx_i;
  logic [NR*DW-1:0] rf_data_i;
  logic [NR*DW-1:0] opnd_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  wbfwd_top #(.IDX_W(IW), .DATA_W(DW), .NUM_RD(NR)) u_wbfwd_top (
    .clk           (clk),
    .rst_n         (rst_n),
    .stall_i       (stall_i),
    .commit_vld_i  (commit_vld_i),
    .commit_idx_i  (commit_idx_i),
    .commit_data_i (commit_data_i),
    .rd_idx_i      (rd_idx_i),
    .rf_data_i     (rf_data_i),
    .opnd_o        (opnd_o)
  );

  task automatic check(input string req, input int port, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s port%0d: actual=%h expected=%h", req, port, act, exp);
    end
  endtask

  task automatic apply_reset();
    rst_n = 1'b0; stall_i = 1'b0; commit_vld_i = 1'b0;
    commit_idx_i = '0; commit_data_i = '0; rd_idx_i = '0; rf_data_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One cycle: drive after the falling edge, sample before the rising edge.
  task automatic step(input logic st, input logic cv, input logic [IW-1:0] ci,
                      input logic [DW-1:0] cd,
                      input logic [IW-1:0] r0, input logic [DW-1:0] f0, input logic [DW-1:0] e0,
                      input string q0,
                      input logic [IW-1:0] r1, input logic [DW-1:0] f1, input logic [DW-1:0] e1,
                      input string q1);
    @(negedge clk);
    stall_i = st; commit_vld_i = cv; commit_idx_i = ci; commit_data_i = cd;
    rd_idx_i = {r1, r0}; rf_data_i = {f1, f0};
    #1;
    check(q0, 0, opnd_o[DW-1:0], e0);
    check(q1, 1, opnd_o[2*DW-1:DW], e1);
  endtask

  task automatic t_reset();
    apply_reset();
    // R7: empty records never match, so the register-file data is returned
    step(0, 0, 5'd0, 32'h0, 5'd3, 32'hAAAA_0003, 32'hAAAA_0003, "R7",
                            5'd4, 32'hAAAA_0004, 32'hAAAA_0004, "R7");
  endtask

  task automatic t_priority();
    // R1 commit wins on port 0; port 1 misses and takes RF data (R4)
    step(0, 1, 5'd3, 32'h11, 5'd3, 32'hDEAD, 32'h11, "R1", 5'd4, 32'h44, 32'h44, "R4");
    // R2 newer record, R1 on the other port (R9)
    step(0, 1, 5'd4, 32'h22, 5'd3, 32'hDEAD, 32'h11, "R2", 5'd4, 32'hDEAD, 32'h22, "R1");
    // R3 older record, R2 newer record, R5 shift visible
    step(0, 0, 5'd0, 32'h0, 5'd3, 32'hDEAD, 32'h11, "R3", 5'd4, 32'hDEAD, 32'h22, "R5");
    // R1 beats a valid newer record on the same index
    step(0, 1, 5'd4, 32'h33, 5'd3, 32'hDEAD, 32'h11, "R3", 5'd4, 32'hDEAD, 32'h33, "R1");
    // now newer=(4,33), older=(4,22): newer must win; R4 on a miss
    step(0, 0, 5'd0, 32'h0, 5'd9, 32'h99, 32'h99, "R4", 5'd4, 32'hDEAD, 32'h33, "R2");
  endtask

  task automatic t_zero();
    // R6 reading index 0 while index 0 is committed
    step(0, 1, 5'd0, 32'h55, 5'd0, 32'h77, 32'h0, "R6", 5'd4, 32'hEE, 32'h33, "R2");
    step(0, 1, 5'd0, 32'h56, 5'd0, 32'h78, 32'h0, "R6", 5'd9, 32'h9A, 32'h9A, "R4");
    // two index-0 commits later, newer record still (4,33)
    step(0, 0, 5'd0, 32'h0, 5'd4, 32'hEE, 32'h33, "R6", 5'd0, 32'h79, 32'h0, "R6");
  endtask

  task automatic t_stall();
    step(0, 1, 5'd5, 32'h100, 5'd5, 32'hBAD, 32'h100, "R1", 5'd0, 32'h0, 32'h0, "R6");
    // load commits during stall; held reader of r5 sees newer record
    step(1, 1, 5'd6, 32'h7, 5'd5, 32'hBAD, 32'h100, "R2", 5'd6, 32'hBAD, 32'h7, "R8");
    // still stalled: r5 now only in the older record
    step(1, 0, 5'd0, 32'h0, 5'd5, 32'hBAD, 32'h100, "R8", 5'd6, 32'hBAD, 32'h7, "R8");
    step(0, 0, 5'd0, 32'h0, 5'd5, 32'hBAD, 32'h100, "R3", 5'd6, 32'hBAD, 32'h7, "R2");
  endtask

  // Program-order reference: register file trails the committed state by two commits.
  task automatic t_random(input int cycles);
    logic [DW-1:0] arch [32];
    logic [DW-1:0] rfm  [32];
    logic [IW-1:0] p_idx [2];
    logic [DW-1:0] p_dat [2];
    logic          p_vld [2];
    apply_reset();
    for (int i = 0; i < 32; i++) begin
      arch[i] = (i == 0) ? '0 : $urandom;
      rfm[i]  = arch[i];
    end
    for (int k = 0; k < 2; k++) begin
      p_vld[k] = 1'b0; p_idx[k] = '0; p_dat[k] = '0;
    end
    for (int c = 0; c < cycles; c++) begin
      logic          cv;
      logic [IW-1:0] ci, ra, rb;
      logic [DW-1:0] cd, ea, eb;
      cv = ($urandom % 4) != 0;
      ci = ($urandom % 3 == 0) ? IW'($urandom % 4) : IW'($urandom);
      cd = $urandom;
      ra = ($urandom % 2 == 0) ? ci : IW'($urandom % 8);
      rb = ($urandom % 2 == 0) ? p_idx[1] : IW'($urandom);
      ea = (cv && ci == ra) ? cd : arch[ra];
      eb = (cv && ci == rb) ? cd : arch[rb];
      if (ra == '0) ea = '0;
      if (rb == '0) eb = '0;
      // R9: ports read independently under random stall (R8)
      step(logic'($urandom % 3 == 0), cv, ci, cd,
           ra, rfm[ra], ea, "R9", rb, rfm[rb], eb, "R9");
      if (cv && ci != '0) begin
        if (p_vld[1]) rfm[p_idx[1]] = p_dat[1];
        p_vld[1] = p_vld[0]; p_idx[1] = p_idx[0]; p_dat[1] = p_dat[0];
        p_vld[0] = 1'b1;     p_idx[0] = ci;       p_dat[0] = cd;
        arch[ci] = cd;
      end
    end
  endtask

  initial begin
    t_reset();
    t_priority();
    t_zero();
    t_stall();
    t_random(2000);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5 * 100000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule